// File: doc/BRIEF.md
# Indexed address generation unit

This unit forms the 16-bit data-memory address for the memory-operand instructions of an 8-bit core. It owns four 16-bit index registers. Each of them is visible to the core as two byte registers in a 16-slot byte register map. The instruction decoder presents an addressing-mode code and an index select. It also presents an 8-bit offset field, a direction bit, the current value of general register R3, and a direct-address field that is held in complemented form. The unit returns an effective address and, for the auto-modify modes, a strobe and a new index value. The memory and the ALU sit outside the unit.

A transaction runs through a small state machine with three states. In `S_IDLE` a request is accepted: the operands are captured and the address is computed from the current index value. This moves the machine to `S_ISSUE`, where the address is presented for one cycle. The machine then always moves to `S_COMMIT`, which raises the write-back strobe for one cycle. From `S_COMMIT` it always returns to `S_IDLE`, and the new index value is stored on that last edge. The index update therefore lands after the memory access. If the core writes a byte of the same index register during the transaction, the auto-modify value still ends up as the final contents.

Mode codes are: 0 = offset, 1 = auto-modify, 2 = R3-indexed, 3 = direct.

Top module: `idx_agu`

## Requirements
- R1: After reset all four index registers read 0x0000, `addr_valid` and `ix_wb` are low, `mem_addr` is 0x0000, and the state is `S_IDLE`.
- R2: A byte-register write with select s in 0..7 loads index register s/2: the low byte when s is even and the high byte when s is odd. A select of 8..15 has no effect on any index register.
- R3: Offset mode (mode 0): the address is the index plus the zero-extended 8-bit offset, and the index register is not modified (`ix_wb` stays low).
- R4: Auto-modify with the direction bit set (mode 1, `dec_sign`=1) is the pre-decrement form. The address is the index plus offset[6:0] with bits 15..7 forced to 1 (OR 0xFF80). The index register is loaded with that same address.
- R5: Auto-modify with the direction bit clear (mode 1, `dec_sign`=0) is the post-increment form. The address is the current index, and the index register becomes the index plus offset[6:0]. Offset bit 7 is ignored in both auto-modify forms.
- R6: R3-indexed mode (mode 2): the address is the index plus the zero-extended `r3_val`, with no index update.
- R7: Direct mode (mode 3): the address is the bitwise complement of `dir_n`, zero-extended, so it always lies in 0x0000..0x00FF. The index register is neither read nor updated.
- R8: A request accepted at clock edge k gives `addr_valid` high for exactly the cycle after edge k. `ix_wb` can be high only in the cycle after that. The two are never high together.
- R9: The index write-back occurs after the address cycle and takes precedence. A byte-register write to the same index register during the transaction is overwritten, while a write to a different index register during the transaction is kept.
- R10: A request presented while a transaction is in progress (states `S_ISSUE`, `S_COMMIT`) is ignored and causes no extra address cycle.
- R11: All address and index arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start a transaction (accepted in `S_IDLE` only) |
| mode | input | 2 | Addressing mode: 0 offset, 1 auto-modify, 2 R3-indexed, 3 direct |
| ix_sel | input | 2 | Index register select |
| offset | input | 8 | Offset field; bits 6..0 only in auto-modify mode |
| dec_sign | input | 1 | Auto-modify direction: 1 pre-decrement, 0 post-increment |
| r3_val | input | 8 | Current value of R3 |
| dir_n | input | 8 | Complemented direct address |
| reg_we | input | 1 | Byte-register write strobe from the core |
| reg_sel | input | 4 | Byte-register map slot being written |
| reg_wdata | input | 8 | Byte-register write data |
| addr_valid | output | 1 | Effective address valid this cycle |
| mem_addr | output | 16 | Effective address |
| ix_wb | output | 1 | Index write-back strobe |
| ix_new | output | 16 | New index value accompanying `ix_wb` |

## Verification
The index registers are not visible at the ports. Their contents show up only as the address of a later offset-mode access with a zero offset, so a corrupted index register is revealed one full transaction later (three cycles). A wrong auto-modify result appears twice: at once on `ix_new` in the commit cycle, and again as a wrong address on the next access to that register. Ordering faults show up in the same transaction. These include a strobe in the wrong cycle, a lost precedence of write-back over a concurrent byte write, and a request taken while busy. They appear as `ix_wb` not directly following `addr_valid`, a surviving byte value, or an unexpected extra address cycle.

// File: rtl/agu_pkg.sv
package agu_pkg;
    typedef enum logic [1:0] {
        AM_OFFSET = 2'd0,
        AM_AUTO   = 2'd1,
        AM_REGIX  = 2'd2,
        AM_DIRECT = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_ISSUE  = 2'd1,
        S_COMMIT = 2'd2
    } seq_state_e;
endpackage

// File: rtl/agu_idx_file.sv
module agu_idx_file #(
    parameter int NUM_IX = 4,
    parameter int BYTE_W = 8,
    parameter int SEL_W  = 4,
    localparam int IX_W  = 2 * BYTE_W,
    localparam int IXS_W = (NUM_IX > 1) ? $clog2(NUM_IX) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_we,
    input  logic [SEL_W-1:0]         reg_sel,
    input  logic [BYTE_W-1:0]        reg_wdata,
    input  logic                     wb_en,
    input  logic [IXS_W-1:0]         wb_sel,
    input  logic [IX_W-1:0]          wb_val,
    output logic [NUM_IX*IX_W-1:0]   ix_flat
);
    localparam int MAP_SLOTS = 2 * NUM_IX;

    logic [IX_W-1:0] ix_q [NUM_IX];

    for (genvar g = 0; g < NUM_IX; g++) begin : g_ix
        localparam logic [SEL_W-1:0] LO_SLOT = SEL_W'(2 * g);
        localparam logic [SEL_W-1:0] HI_SLOT = SEL_W'(2 * g + 1);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ix_q[g] <= '0;
            end else if (wb_en && (wb_sel == IXS_W'(g))) begin
                ix_q[g] <= wb_val;
            end else if (reg_we && (reg_sel == LO_SLOT)) begin
                ix_q[g][BYTE_W-1:0] <= reg_wdata;
            end else if (reg_we && (reg_sel == HI_SLOT)) begin
                ix_q[g][IX_W-1:BYTE_W] <= reg_wdata;
            end
        end

        assign ix_flat[g*IX_W +: IX_W] = ix_q[g];
    end

    // R9: the write-back value is what the selected register holds afterwards
    a_r9_wb_final: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> (ix_q[$past(wb_sel)] == $past(wb_val)));

    // R2: slots above the index bytes leave every index register untouched
    a_r2_upper_slots_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && (int'(reg_sel) >= MAP_SLOTS) && !wb_en) |=> $stable(ix_flat));
endmodule

// File: rtl/agu_ea_calc.sv
module agu_ea_calc
    import agu_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int DISP_W = 7,
    localparam int IX_W  = 2 * BYTE_W
) (
    input  amode_e              mode,
    input  logic [IX_W-1:0]     ix_val,
    input  logic [BYTE_W-1:0]   offset,
    input  logic                dec_sign,
    input  logic [BYTE_W-1:0]   r3_val,
    input  logic [BYTE_W-1:0]   dir_n,
    output logic [IX_W-1:0]     ea,
    output logic                wb,
    output logic [IX_W-1:0]     nv
);
    localparam logic [IX_W-1:0] PRE_MASK = ~IX_W'((1 << DISP_W) - 1);

    logic [IX_W-1:0] disp_z;
    logic [IX_W-1:0] off_z;
    logic [IX_W-1:0] r3_z;

    assign disp_z = {{(IX_W-DISP_W){1'b0}}, offset[DISP_W-1:0]};
    assign off_z  = {{BYTE_W{1'b0}}, offset};
    assign r3_z   = {{BYTE_W{1'b0}}, r3_val};

    always_comb begin
        ea = ix_val;
        wb = 1'b0;
        nv = ix_val;
        unique case (mode)
            AM_OFFSET: begin
                ea = ix_val + off_z;
            end
            AM_AUTO: begin
                wb = 1'b1;
                if (dec_sign) begin
                    ea = ix_val + (disp_z | PRE_MASK);
                    nv = ix_val + (disp_z | PRE_MASK);
                end else begin
                    ea = ix_val;
                    nv = ix_val + disp_z;
                end
            end
            AM_REGIX: begin
                ea = ix_val + r3_z;
            end
            AM_DIRECT: begin
                ea = {{BYTE_W{1'b0}}, ~dir_n};
            end
        endcase
    end
endmodule

// File: rtl/agu_seq.sv
module agu_seq
    import agu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic capture,
    output logic addr_phase,
    output logic wb_phase
);
    seq_state_e state_q;
    seq_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (req) state_d = S_ISSUE;
            S_ISSUE:  state_d = S_COMMIT;
            S_COMMIT: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_comb begin
        capture    = 1'b0;
        addr_phase = 1'b0;
        wb_phase   = 1'b0;
        unique case (state_q)
            S_IDLE:   capture    = req;
            S_ISSUE:  addr_phase = 1'b1;
            S_COMMIT: wb_phase   = 1'b1;
            default:  ;
        endcase
    end

    // R8: the address phase lasts one cycle and is followed by the commit phase
    a_r8_single_addr: assert property (@(posedge clk) disable iff (!rst_n)
        addr_phase |=> (!addr_phase && wb_phase));

    // R8: the commit phase only ever follows an address phase
    a_r8_wb_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
        wb_phase |-> $past(addr_phase));

    // R10: no capture while a transaction is in progress
    a_r10_busy_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_phase || wb_phase) |-> !capture);
endmodule

// File: rtl/idx_agu.sv
module idx_agu
    import agu_pkg::*;
#(
    parameter int NUM_IX = 4,
    parameter int BYTE_W = 8,
    parameter int DISP_W = 7,
    parameter int SEL_W  = 4,
    localparam int IX_W  = 2 * BYTE_W,
    localparam int IXS_W = (NUM_IX > 1) ? $clog2(NUM_IX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [1:0]        mode,
    input  logic [IXS_W-1:0]  ix_sel,
    input  logic [BYTE_W-1:0] offset,
    input  logic              dec_sign,
    input  logic [BYTE_W-1:0] r3_val,
    input  logic [BYTE_W-1:0] dir_n,
    input  logic              reg_we,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic              addr_valid,
    output logic [IX_W-1:0]   mem_addr,
    output logic              ix_wb,
    output logic [IX_W-1:0]   ix_new
);
    logic [NUM_IX*IX_W-1:0] ix_flat;
    logic [IX_W-1:0]        ix_cur;
    logic                   capture;
    logic                   addr_phase;
    logic                   wb_phase;
    logic [IX_W-1:0]        ea_c;
    logic                   wb_c;
    logic [IX_W-1:0]        nv_c;

    logic [IX_W-1:0]        ea_q;
    logic                   wb_q;
    logic [IX_W-1:0]        nv_q;
    logic [IXS_W-1:0]       sel_q;
    amode_e                 mode_q;
    logic                   sign_q;

    assign ix_cur = ix_flat[ix_sel*IX_W +: IX_W];

    agu_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .capture    (capture),
        .addr_phase (addr_phase),
        .wb_phase   (wb_phase)
    );

    agu_ea_calc #(.BYTE_W(BYTE_W), .DISP_W(DISP_W)) u_calc (
        .mode     (amode_e'(mode)),
        .ix_val   (ix_cur),
        .offset   (offset),
        .dec_sign (dec_sign),
        .r3_val   (r3_val),
        .dir_n    (dir_n),
        .ea       (ea_c),
        .wb       (wb_c),
        .nv       (nv_c)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q   <= '0;
            wb_q   <= 1'b0;
            nv_q   <= '0;
            sel_q  <= '0;
            mode_q <= AM_OFFSET;
            sign_q <= 1'b0;
        end else if (capture) begin
            ea_q   <= ea_c;
            wb_q   <= wb_c;
            nv_q   <= nv_c;
            sel_q  <= ix_sel;
            mode_q <= amode_e'(mode);
            sign_q <= dec_sign;
        end
    end

    assign addr_valid = addr_phase;
    assign mem_addr   = ea_q;
    assign ix_wb      = wb_phase && wb_q;
    assign ix_new     = nv_q;

    agu_idx_file #(.NUM_IX(NUM_IX), .BYTE_W(BYTE_W), .SEL_W(SEL_W)) u_file (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .wb_en     (ix_wb),
        .wb_sel    (sel_q),
        .wb_val    (nv_q),
        .ix_flat   (ix_flat)
    );

    // R7: a direct access stays inside the first 256 bytes
    a_r7_direct_page: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && mode_q == AM_DIRECT) |-> (mem_addr[IX_W-1:BYTE_W] == '0));

    // R4: pre-decrement stores exactly the address it issued
    a_r4_pre_matches_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (ix_wb && mode_q == AM_AUTO && sign_q) |-> (ix_new == $past(mem_addr)));

    // R3/R6/R7: non-modifying modes never raise the write-back strobe
    a_r3_no_wb_plain: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && mode_q != AM_AUTO) |=> !ix_wb);
endmodule

// File: tb/sim_idx_agu.sv
module sim_idx_agu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [1:0]  ix_sel = 2'd0;
    logic [7:0]  offset = 8'd0;
    logic        dec_sign = 1'b0;
    logic [7:0]  r3_val = 8'd0;
    logic [7:0]  dir_n = 8'd0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_sel = 4'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic        addr_valid;
    logic [15:0] mem_addr;
    logic        ix_wb;
    logic [15:0] ix_new;

    always #5 clk = ~clk;

    idx_agu u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .ix_sel(ix_sel),
        .offset(offset), .dec_sign(dec_sign), .r3_val(r3_val), .dir_n(dir_n),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .addr_valid(addr_valid), .mem_addr(mem_addr), .ix_wb(ix_wb), .ix_new(ix_new)
    );

    typedef struct {
        logic [15:0] a;
        logic        wb;
        logic [15:0] nv;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [15:0] mix [4];
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [1:0] m, input logic [1:0] s, input logic [7:0] o,
                                   input logic sg, input logic [7:0] r3, input logic [7:0] dn,
                                   input string tag);
        exp_t e;
        logic [15:0] ix;
        logic [15:0] d;
        ix = mix[s];
        d = {9'd0, o[6:0]};
        e.tag = tag; e.wb = 1'b0; e.nv = ix;
        case (m)
            2'd0: e.a = ix + {8'd0, o};
            2'd1: begin
                e.wb = 1'b1;
                if (sg) begin e.a = ix + (d | 16'hFF80); e.nv = e.a; end
                else    begin e.a = ix; e.nv = ix + d; end
            end
            2'd2: e.a = ix + {8'd0, r3};
            default: e.a = {8'd0, ~dn};
        endcase
        return e;
    endfunction

    task automatic wr(input logic [3:0] s, input logic [7:0] d);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (s < 4'd8) begin
            if (s[0]) mix[s[2:1]][15:8] = d;
            else      mix[s[2:1]][7:0]  = d;
        end
    endtask

    // one full transaction; optional concurrent byte write and held request
    task automatic xact(input logic [1:0] m, input logic [1:0] s, input logic [7:0] o,
                        input logic sg, input logic [7:0] r3, input logic [7:0] dn,
                        input string tag, input bit cw = 1'b0, input logic [3:0] cws = 4'd0,
                        input logic [7:0] cwd = 8'd0, input bit hold = 1'b0);
        exp_t e;
        e = model(m, s, o, sg, r3, dn, tag);
        sb.push_back(e);
        mode = m; ix_sel = s; offset = o; dec_sign = sg; r3_val = r3; dir_n = dn;
        req = 1'b1;
        @(negedge clk);
        if (cw) begin reg_we = 1'b1; reg_sel = cws; reg_wdata = cwd; end
        if (hold) begin mode = 2'd3; dir_n = 8'h00; ix_sel = ~s; end
        else req = 1'b0;
        @(negedge clk);
        reg_we = 1'b0; req = 1'b0;
        @(negedge clk);
        if (cw && cws < 4'd8) begin
            if (cws[0]) mix[cws[2:1]][15:8] = cwd;
            else        mix[cws[2:1]][7:0]  = cwd;
        end
        if (e.wb) mix[s] = e.nv;
        if (hold) chk(addr_valid == 1'b0, "R10 no extra address cycle", {15'd0, addr_valid}, 16'h0);
    endtask

    task automatic peek(input logic [1:0] s, input string tag);
        xact(2'd0, s, 8'h00, 1'b0, 8'h00, 8'h00, tag);
    endtask

    // monitor: pops the scoreboard whenever an address cycle appears
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && addr_valid) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R10 unexpected address cycle", mem_addr, 16'h0);
                end else begin
                    e = sb.pop_front();
                    chk(mem_addr == e.a, {e.tag, " address"}, mem_addr, e.a);
                    @(negedge clk);
                    chk(ix_wb == e.wb, {"R8 strobe follows address, ", e.tag}, {15'd0, ix_wb}, {15'd0, e.wb});
                    chk(addr_valid == 1'b0, "R8 address one cycle only", {15'd0, addr_valid}, 16'h0);
                    if (e.wb) chk(ix_new == e.nv, {e.tag, " new index"}, ix_new, e.nv);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) mix[i] = 16'h0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(addr_valid == 1'b0, "R1 addr_valid low", {15'd0, addr_valid}, 16'h0);
        chk(ix_wb == 1'b0, "R1 ix_wb low", {15'd0, ix_wb}, 16'h0);
        chk(mem_addr == 16'h0, "R1 mem_addr zero", mem_addr, 16'h0);
        for (int i = 0; i < 4; i++) peek(2'(i), "R1 index cleared");

        // R2 byte writes into the map
        wr(4'd0, 8'h34); wr(4'd1, 8'h12);
        wr(4'd5, 8'hAB); wr(4'd4, 8'hCD);
        peek(2'd0, "R2 i0 bytes");
        peek(2'd2, "R2 i2 bytes");
        wr(4'd11, 8'h77); wr(4'd15, 8'h99); wr(4'd8, 8'h55);
        for (int i = 0; i < 4; i++) peek(2'(i), "R2 upper slots ignored");

        // R3 offset mode
        xact(2'd0, 2'd0, 8'h10, 1'b0, 8'h00, 8'h00, "R3 offset small");
        xact(2'd0, 2'd0, 8'hFF, 1'b1, 8'h00, 8'h00, "R3 offset full byte");
        peek(2'd0, "R3 index unchanged");

        // R4 pre-decrement
        wr(4'd2, 8'h00); wr(4'd3, 8'h01);
        xact(2'd1, 2'd1, 8'h05, 1'b1, 8'h00, 8'h00, "R4 pre-decrement");
        peek(2'd1, "R4 index loaded");
        xact(2'd1, 2'd1, 8'h80, 1'b1, 8'h00, 8'h00, "R4 pre-decrement zero disp");

        // R5 post-increment, offset bit 7 ignored
        xact(2'd1, 2'd1, 8'h83, 1'b0, 8'h00, 8'h00, "R5 post-increment");
        peek(2'd1, "R5 index advanced");

        // R6 and R11 register-indexed with wrap
        wr(4'd6, 8'hF0); wr(4'd7, 8'hFF);
        xact(2'd2, 2'd3, 8'h00, 1'b0, 8'h20, 8'h00, "R11 R6 wrap");
        xact(2'd2, 2'd0, 8'h55, 1'b0, 8'h80, 8'h00, "R6 r3 index");
        xact(2'd1, 2'd3, 8'h7F, 1'b0, 8'h00, 8'h00, "R11 post wrap");
        peek(2'd3, "R11 wrapped index");

        // R7 direct
        xact(2'd3, 2'd2, 8'h00, 1'b0, 8'h00, 8'h5A, "R7 direct");
        xact(2'd3, 2'd2, 8'h00, 1'b1, 8'h00, 8'h00, "R7 direct top");
        peek(2'd2, "R7 index untouched");

        // R9 write-back precedence
        xact(2'd1, 2'd0, 8'h7F, 1'b0, 8'h00, 8'h00, "R9 same index", 1'b1, 4'd0, 8'hEE);
        peek(2'd0, "R9 write-back wins");
        xact(2'd1, 2'd1, 8'h02, 1'b1, 8'h00, 8'h00, "R9 other index", 1'b1, 4'd6, 8'h3C);
        peek(2'd3, "R9 other write kept");
        peek(2'd1, "R9 own update");

        // R10 request held during the transaction
        xact(2'd0, 2'd2, 8'h01, 1'b0, 8'h00, 8'h00, "R10 held request", 1'b0, 4'd0, 8'h00, 1'b1);
        peek(2'd2, "R10 state intact");

        repeat (4) @(negedge clk);
        if (sb.size() != 0) chk(1'b0, "R8 missing address cycles", 16'(sb.size()), 16'h0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule